// File: doc/BRIEF.md
# Block-Length SPI Master with Word FIFO

This block is an SPI master that moves a whole block of bytes per command. Software programs a byte count and a transfer direction, picks one of four target devices, and then sets a start flag. Payload bytes travel through a single 32-bit data register backed by a small FIFO. For an outgoing block, software pushes words and the engine shifts their bytes out. For an incoming block, the engine packs received bytes into words and software pops them.

Bytes are packed little-endian within each FIFO word. The serial engine runs SPI mode 0, most significant bit first, at a fixed fraction of the system clock. The chosen chip select stays asserted for the whole block. The engine pauses between bytes whenever the FIFO cannot supply or accept data, and resumes without losing data. A status bit tells software when the FIFO is blocking it.

Top module: `blk_spi_master`

## Requirements
- R1: After reset, spi_cs_n is all ones, spi_sclk is 0, and the control, length and 0x04 registers read 0. The status register reads 1, because the direction resets to incoming and the FIFO is empty.
- R2: The control register at offset 0x00 holds the device select in bits 7:6 and the direction in bit 13 (1 = outgoing, 0 = incoming). Bit 15 is the busy/start flag; all other bits read 0. Writing bit 15 = 1 starts a block only when the length register at offset 0x08 is nonzero.
- R3: A started block shifts exactly length × 8 serial clock cycles. Busy reads 1 until the last bit has shifted, then returns to 0. spi_sclk stays low while the block is idle.
- R4: While busy, only the selected spi_cs_n bit is low, and it does not change during the block. All chip selects are high when idle.
- R5: The outgoing mode uses SPI mode 0, MSB first. MOSI is driven on the falling edge and sampled on the rising edge. Byte k of the block is bits 8×(k mod 4)+7 down to 8×(k mod 4) of FIFO word k/4. Unused upper bytes of the final word are never sent.
- R6: The incoming mode drives MOSI high (0xFF per byte) and samples MISO on the rising edge. Each received byte is placed little-endian into its word, and unused upper bytes of the final word read 0.
- R7: The FIFO holds 4 words, and the data register sits at offset 0x0C. In outgoing mode, status bit 0 (offset 0x10) is 1 when the FIFO is full, and a push into a full FIFO is dropped. In incoming mode, status bit 0 is 1 when the FIFO is empty, and a read from an empty FIFO returns 0 and pops nothing.
- R8: The engine waits before a byte while an outgoing FIFO is empty or an incoming FIFO is full. It continues once software pushes or pops, and no byte is lost or repeated.
- R9: Writes to the control or length register while busy have no effect.
- R10: A control write that changes the direction bit empties the FIFO. Writes to offset 0x04 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects, one per device |

## Verification
The bench builds the block with a serial clock divider of 2, the default 4-word FIFO and a 16-bit length. This keeps blocks of up to 20 bytes short, so both FIFO limits can be reached in a few thousand cycles. With these values, an incoming block longer than 16 bytes stalls at exactly byte 16. An outgoing block fed one word at a time stalls after byte 4. The FIFO-full flag and the dropped fifth push can be seen directly, before any transfer starts.

// File: rtl/blk_spi_master.sv
module blk_spi_master #(
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [3:0]  spi_cs_n
);
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [1:0]       dev;
  logic             dir, busy, act, sclk_q, rbit;
  logic [LEN_W-1:0] len_q, rem;
  logic [1:0]       bidx;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic [DW-1:0]    dcnt;
  logic [31:0]      acc;
  logic [31:0]      mem [FIFO_DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  wire ctrl_wr  = bus_sel & bus_we & (bus_addr == 5'h00) & ~busy;
  wire len_wr   = bus_sel & bus_we & (bus_addr == 5'h08) & ~busy;
  wire empty    = (cnt == '0);
  wire full     = (cnt == CW'(FIFO_DEPTH));
  wire can_go   = dir ? ~empty : ~full;
  wire tick     = (dcnt == DW'(CLK_DIV - 1));
  wire bdone    = act & tick & sclk_q & (bitn == 3'd7);
  wire last     = (rem == LEN_W'(1));
  wire wdone    = bdone & ((bidx == 2'd3) | last);
  wire bus_push = bus_sel & bus_we & (bus_addr == 5'h0C) & dir & ~full;
  wire bus_pop  = bus_sel & ~bus_we & (bus_addr == 5'h0C) & ~dir & ~empty;
  wire push     = bus_push | (wdone & ~dir);
  wire pop      = bus_pop | (wdone & dir);
  wire flush    = ctrl_wr & (bus_wdata[13] != dir);

  wire [31:0] head    = mem[rp];
  wire [7:0]  rx_byte = {sh[6:0], rbit};
  wire [31:0] acc_n   = acc | ({24'b0, rx_byte} << {bidx, 3'b000});
  wire [7:0]  tx_byte = dir ? head[{bidx, 3'b000} +: 8] : 8'hFF;

  assign spi_sclk = sclk_q;
  assign spi_mosi = dir ? sh[7] : 1'b1;
  assign spi_cs_n = busy ? ~(4'b0001 << dev) : 4'b1111;

  always_comb begin
    case (bus_addr)
      5'h00:   bus_rdata = {16'b0, busy, 1'b0, dir, 5'b0, dev, 6'b0};
      5'h08:   bus_rdata = 32'(len_q);
      5'h0C:   bus_rdata = (dir | empty) ? 32'b0 : head;
      5'h10:   bus_rdata = {31'b0, dir ? full : empty};
      default: bus_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) if (push) mem[wp] <= dir ? bus_wdata : acc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev <= '0; dir <= 1'b0; busy <= 1'b0; len_q <= '0; rem <= '0;
      bidx <= '0; act <= 1'b0; sclk_q <= 1'b0; rbit <= 1'b0;
      bitn <= '0; sh <= '0; dcnt <= '0; acc <= '0;
    end else begin
      if (len_wr) len_q <= bus_wdata[LEN_W-1:0];
      if (ctrl_wr) begin
        dev <= bus_wdata[7:6];
        dir <= bus_wdata[13];
        if (bus_wdata[15] && len_q != '0) begin
          busy <= 1'b1; rem <= len_q; bidx <= '0; act <= 1'b0; acc <= '0;
        end
      end
      if (busy) begin
        if (!act) begin
          if (can_go) begin
            act <= 1'b1; sh <= tx_byte; bitn <= '0; dcnt <= '0; sclk_q <= 1'b0;
          end
        end else begin
          dcnt <= tick ? '0 : dcnt + DW'(1);
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rbit   <= spi_miso;
            end else begin
              sclk_q <= 1'b0;
              sh     <= rx_byte;
              bitn   <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                act  <= 1'b0;
                rem  <= rem - LEN_W'(1);
                bidx <= bidx + 2'd1;
                if (!dir) acc <= wdone ? 32'b0 : acc_n;
                if (last) busy <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  p_cs_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(spi_cs_n));
  p_idle_sclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);
  p_busy_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem != '0);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FIFO_DEPTH));
endmodule

// File: tb/sim_blk_spi_master.sv
module sim_blk_spi_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  blk_spi_master #(.CLK_DIV(2), .FIFO_DEPTH(4), .LEN_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n));

  function automatic logic [7:0] pat(input int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction

  // simple SPI slave
  int rcnt = 0, fcnt = 0;
  logic [7:0] cap [64];
  logic [7:0] shcap = '0, ssh = '0;
  wire cs_any = ~&spi_cs_n;
  assign spi_miso = ssh[7];
  always @(posedge cs_any) begin rcnt = 0; fcnt = 0; ssh = pat(0); end
  always @(posedge spi_sclk) begin
    shcap = {shcap[6:0], spi_mosi};
    rcnt++;
    if (rcnt % 8 == 0) cap[(rcnt / 8 - 1) % 64] = shcap;
  end
  always @(negedge spi_sclk) begin
    fcnt++;
    if (fcnt % 8 == 0) ssh = pat(fcnt / 8); else ssh = {ssh[6:0], 1'b0};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(5'h00, v);
      if (!v[15]) return;
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] w0, input logic [31:0] w1, input int k);
    logic [31:0] w;
    w = (k < 4) ? w0 : w1;
    return w[8 * (k % 4) +: 8];
  endfunction

  // {len, word0, word1}
  localparam logic [79:0] VEC [4] = '{
    {16'd1, 32'h111111A5, 32'h0},
    {16'd4, 32'h44332211, 32'h0},
    {16'd6, 32'h0D0C0B0A, 32'hFFEE0F0E},
    {16'd3, 32'hDEC0AD0B, 32'h0}
  };

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ws [5];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 cs_n", {28'b0, spi_cs_n}, 32'hF);
    chk("R1 sclk", {31'b0, spi_sclk}, 0);
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h08, v); chk("R1 len", v, 0);
    rd(5'h04, v); chk("R1 reg04", v, 0);
    rd(5'h10, v); chk("R1 status", v, 1);

    // R2 field readback and zero length start
    wr(5'h00, 32'h0000_A080);
    rd(5'h00, v); chk("R2 readback zero-length start", v, 32'h0000_2080);
    repeat (20) @(negedge clk);
    chk("R2 no shift on zero length", rcnt, 0);

    // table walk: outgoing blocks (R3 R4 R5)
    for (int i = 0; i < 4; i++) begin
      logic [15:0] ln;
      logic [31:0] w0, w1;
      {ln, w0, w1} = VEC[i];
      wr(5'h00, 32'h2000 | (i << 6));
      wr(5'h0C, w0);
      if (ln > 4) wr(5'h0C, w1);
      wr(5'h08, 32'(ln));
      wr(5'h00, 32'hA000 | (i << 6));
      repeat (3) @(negedge clk);
      chk("R4 cs during block", {28'b0, spi_cs_n}, {28'b0, ~(4'b1 << i)});
      wait_idle();
      chk("R4 cs idle", {28'b0, spi_cs_n}, 32'hF);
      chk("R3 edge count", rcnt, 8 * ln);
      for (int k = 0; k < ln; k++)
        chk("R5 tx byte", {24'b0, cap[k]}, {24'b0, exp_byte(w0, w1, k)});
      rd(5'h10, v); chk("R7 not full after block", v, 0);
    end

    // R10 flush on direction change, writes to 0x04 ignored
    wr(5'h0C, 32'h12345678);
    wr(5'h04, 32'hFFFFFFFF);
    rd(5'h04, v); chk("R10 reg04 ignored", v, 0);
    wr(5'h00, 32'h0000_0000);
    rd(5'h10, v); chk("R10 flushed -> empty", v, 1);
    rd(5'h0C, v); chk("R7 empty pop reads zero", v, 0);

    // R7 full flag and dropped fifth push
    wr(5'h00, 32'h0000_2000);
    for (int k = 0; k < 4; k++) begin
      ws[k] = 32'h01020304 * (k + 1) + 32'h10;
      wr(5'h0C, ws[k]);
    end
    rd(5'h10, v); chk("R7 full flag", v, 1);
    wr(5'h0C, 32'hBADBADBA);
    wr(5'h08, 32'd16);
    wr(5'h00, 32'h0000_A000);
    wait_idle();
    chk("R3 16-byte count", rcnt, 128);
    for (int k = 0; k < 16; k++)
      chk("R7 dropped push not sent", {24'b0, cap[k]}, {24'b0, ws[k / 4][8 * (k % 4) +: 8]});

    // R6 incoming block of 6 bytes
    wr(5'h00, 32'h0000_0040);
    wr(5'h08, 32'd6);
    wr(5'h00, 32'h0000_8040);
    repeat (3) @(negedge clk);
    chk("R4 cs dev1", {28'b0, spi_cs_n}, 32'hD);
    wait_idle();
    for (int k = 0; k < 6; k++) chk("R6 mosi high", {24'b0, cap[k]}, 32'hFF);
    rd(5'h10, v); chk("R7 not empty", v, 0);
    rd(5'h0C, v); chk("R6 word0", v, {pat(3), pat(2), pat(1), pat(0)});
    rd(5'h0C, v); chk("R6 partial word zero-filled", v, {16'b0, pat(5), pat(4)});
    rd(5'h10, v); chk("R7 empty flag", v, 1);

    // R8 incoming stall on full FIFO
    wr(5'h08, 32'd20);
    wr(5'h00, 32'h0000_8040);
    repeat (1200) @(negedge clk);
    rd(5'h00, v); chk("R8 busy while stalled", {31'b0, v[15]}, 1);
    chk("R8 stalled at 16 bytes", rcnt, 128);
    for (int k = 0; k < 5; k++) begin
      for (int t = 0; t < 2000; t++) begin
        rd(5'h10, v);
        if (!v[0]) break;
      end
      rd(5'h0C, v);
      chk("R8 rx word", v, {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)});
    end
    wait_idle();
    chk("R3 20-byte count", rcnt, 160);

    // R8 outgoing stall on empty FIFO, R9 writes during busy
    wr(5'h00, 32'h0000_20C0);
    wr(5'h0C, 32'h87654321);
    wr(5'h08, 32'd8);
    wr(5'h00, 32'h0000_A0C0);
    repeat (800) @(negedge clk);
    rd(5'h00, v); chk("R8 busy while out stalled", v, 32'h0000_A0C0);
    chk("R8 out stalled at 4 bytes", rcnt, 32);
    wr(5'h00, 32'h0000_0040);
    wr(5'h08, 32'd3);
    rd(5'h00, v); chk("R9 ctrl write ignored", v, 32'h0000_A0C0);
    rd(5'h08, v); chk("R9 len write ignored", v, 8);
    chk("R9 cs unchanged", {28'b0, spi_cs_n}, 32'h7);
    wr(5'h0C, 32'hCAFEF00D);
    wait_idle();
    chk("R8 out count", rcnt, 64);
    for (int k = 0; k < 8; k++)
      chk("R8 out bytes", {24'b0, cap[k]}, {24'b0, exp_byte(32'h87654321, 32'hCAFEF00D, k)});

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule